// File: doc/BRIEF.md
# Atomic Reservation Monitor

This block keeps the one load-linked / store-conditional reservation of a 32-bit core. Each cycle the core may present one memory instruction together with the value of its base register. The block matches the primary opcode, forms the effective address from the base and a sign-extended 16-bit offset, and keeps a reserve bit and a reserved address up to date.

A load-linked word opens a reservation on its address. A store-conditional word is allowed to write memory only while the reservation is open and its address is exactly the reserved one. Its result is written into the status-register flag. Every store-conditional closes the reservation. An ordinary store of any width that lands in the reserved word closes it too. An exception or interrupt entry also closes it, so a handler can never complete a stale sequence. The core uses `sc_mem_we` to gate the data write of a store-conditional, and uses `flag_we`/`flag_val` to update its status flag.

Top module: `rsv_monitor`

## Requirements
- R1: After reset the reserve bit is clear and the reserved address is zero, so a store-conditional issued before any load-linked fails.
- R2: The primary opcode is `instr[31:26]`: 0x1B is load-linked word, 0x33 is store-conditional word, and 0x36, 0x37 and 0x35 are byte, halfword and word stores. Any other opcode leaves the reservation unchanged and raises no output.
- R3: `eff_addr` is `base_val` plus the sign-extended offset. For stores and store-conditional the offset is `{instr[25:21], instr[10:0]}`. For every other opcode the offset is `instr[15:0]`.
- R4: An accepted load-linked sets the reserve bit and records `eff_addr` at the next clock edge. A store-conditional in the very next cycle sees that reservation.
- R5: A store-conditional succeeds when the reserve bit is set and `eff_addr` equals the reserved address. In that cycle `sc_mem_we`, `flag_we` and `flag_val` are all 1.
- R6: A store-conditional that does not succeed drives `flag_we`=1, `flag_val`=0 and `sc_mem_we`=0.
- R7: Every accepted store-conditional clears the reserve bit, whether it succeeds or fails.
- R8: A byte, halfword or word store clears the reserve bit when `{eff_addr[31:2], 2'b00}` equals the reserved address. A store to any other word leaves the reservation intact.
- R9: In a cycle with `op_valid` low and no exception, the reserve bit and the reserved address keep their values.
- R10: `exc_flush` high clears the reserve bit at the next edge. Any operation in the same cycle is not accepted and drives no output.
- R11: `flag_we` and `sc_mem_we` are never 1 except during an accepted store-conditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A memory instruction is issued this cycle |
| instr | input | 32 | Instruction word |
| base_val | input | 32 | Value of the base register |
| exc_flush | input | 1 | Exception or interrupt entry |
| eff_addr | output | 32 | Computed effective address |
| sc_mem_we | output | 1 | Write enable for the store-conditional data |
| flag_we | output | 1 | Status flag write enable |
| flag_val | output | 1 | Value written to the status flag |

## Verification
Two functions can fall in the same cycle. The first pair is a reservation update and a reservation test: a load-linked followed at once by a store-conditional, or a store followed at once by a store-conditional. The second pair is an exception and a load-linked or store-conditional issued together. The bench provokes both pairs in directed sequences. It also runs a long pseudo-random stream that draws addresses from a pool of a few words, so that hits, near-misses within a word and back-to-back updates occur often. Each cycle's outputs are compared with a reservation model kept in the bench and derived from the requirements.

// File: rtl/rsvmon_pkg.sv
package rsvmon_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_LL   = 3'd1,
    OP_SC   = 3'd2,
    OP_SB   = 3'd3,
    OP_SH   = 3'd4,
    OP_SW   = 3'd5
  } mem_op_e;
endpackage

// File: rtl/rsv_decode.sv
module rsv_decode
  import rsvmon_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int OPC_W   = 6,
  parameter int IMM_W   = 16,
  parameter logic [OPC_W-1:0] OPC_LL = 6'h1B,
  parameter logic [OPC_W-1:0] OPC_SC = 6'h33,
  parameter logic [OPC_W-1:0] OPC_SW = 6'h35,
  parameter logic [OPC_W-1:0] OPC_SB = 6'h36,
  parameter logic [OPC_W-1:0] OPC_SH = 6'h37
) (
  input  logic [INSTR_W-1:0] instr_i,
  output mem_op_e            op_o,
  output logic [IMM_W-1:0]   offset_o
);
  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int LO_W    = 11;
  localparam int HI_W    = IMM_W - LO_W;

  logic [OPC_W-1:0] opc;
  logic             split_form;

  assign opc = instr_i[INSTR_W-1:OPC_LSB];

  always_comb begin
    op_o = OP_NONE;
    if (opc == OPC_LL)      op_o = OP_LL;
    else if (opc == OPC_SC) op_o = OP_SC;
    else if (opc == OPC_SB) op_o = OP_SB;
    else if (opc == OPC_SH) op_o = OP_SH;
    else if (opc == OPC_SW) op_o = OP_SW;
  end

  assign split_form = (op_o == OP_SC) || (op_o == OP_SB) ||
                      (op_o == OP_SH) || (op_o == OP_SW);

  always_comb begin
    if (split_form)
      offset_o = {instr_i[25 -: HI_W], instr_i[LO_W-1:0]};
    else
      offset_o = instr_i[IMM_W-1:0];
  end
endmodule

// File: rtl/rsv_agu.sv
module rsv_agu #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] offset_sx;

  assign offset_sx = {{EXT_W{offset_i[IMM_W-1]}}, offset_i};
  assign addr_o    = base_i + offset_sx;
endmodule

// File: rtl/rsv_state.sv
module rsv_state
  import rsvmon_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid_i,
  input  mem_op_e           op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              exc_i,
  output logic              sc_mem_we_o,
  output logic              flag_we_o,
  output logic              flag_val_o
);
  localparam int LSB_W = $clog2(WORD_BYTES);

  logic              rsv_q, rsv_d;
  logic [ADDR_W-1:0] rsv_addr_q, rsv_addr_d;
  logic              accept, upd_en, is_store, sc_hit, word_hit;
  logic [ADDR_W-1:0] addr_word;

  assign accept    = op_valid_i && !exc_i && (op_i != OP_NONE);
  assign is_store  = (op_i == OP_SB) || (op_i == OP_SH) || (op_i == OP_SW);
  assign addr_word = {addr_i[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
  assign sc_hit    = rsv_q && (addr_i == rsv_addr_q);
  assign word_hit  = rsv_q && (addr_word == rsv_addr_q);
  assign upd_en    = accept || exc_i;

  assign flag_we_o   = accept && (op_i == OP_SC);
  assign flag_val_o  = flag_we_o && sc_hit;
  assign sc_mem_we_o = flag_val_o;

  always_comb begin
    rsv_d      = rsv_q;
    rsv_addr_d = rsv_addr_q;
    if (exc_i) begin
      rsv_d = 1'b0;
    end else if (accept) begin
      if (op_i == OP_LL) begin
        rsv_d      = 1'b1;
        rsv_addr_d = addr_i;
      end else if (op_i == OP_SC) begin
        rsv_d = 1'b0;
      end else if (is_store && word_hit) begin
        rsv_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsv_q      <= 1'b0;
      rsv_addr_q <= '0;
    end else if (upd_en) begin
      rsv_q      <= rsv_d;
      rsv_addr_q <= rsv_addr_d;
    end
  end

  AST_LL_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && !exc_i && op_i == OP_LL) |=> (rsv_q && rsv_addr_q == $past(addr_i))) // R4
    else $error("LL did not open reservation");
  AST_SC_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && !exc_i && op_i == OP_SC) |=> !rsv_q) // R7
    else $error("SC left reservation open");
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid_i && !exc_i) |=> ($stable(rsv_q) && $stable(rsv_addr_q))) // R9
    else $error("reservation changed while idle");
  AST_EXC_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    exc_i |=> !rsv_q) // R10
    else $error("exception left reservation open");
  AST_FLAG_ONLY_SC: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we_o || sc_mem_we_o) |-> (op_valid_i && op_i == OP_SC && !exc_i)) // R11
    else $error("flag write outside SC");
  AST_WE_NEEDS_RSV: assert property (@(posedge clk) disable iff (!rst_n)
    sc_mem_we_o |-> (rsv_q && flag_we_o && flag_val_o)) // R5
    else $error("SC write without reservation");
  AST_STORE_HIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid_i && !exc_i && is_store && word_hit) |=> !rsv_q) // R8
    else $error("store to reserved word kept reservation");
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
  import rsvmon_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSTR_W    = 32,
  parameter int OPC_W      = 6,
  parameter int IMM_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              exc_flush,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              sc_mem_we,
  output logic              flag_we,
  output logic              flag_val
);
  mem_op_e           op_kind;
  logic [IMM_W-1:0]  offset;

  rsv_decode #(
    .INSTR_W (INSTR_W),
    .OPC_W   (OPC_W),
    .IMM_W   (IMM_W)
  ) u_decode (
    .instr_i  (instr),
    .op_o     (op_kind),
    .offset_o (offset)
  );

  rsv_agu #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W)
  ) u_agu (
    .base_i   (base_val),
    .offset_i (offset),
    .addr_o   (eff_addr)
  );

  rsv_state #(
    .ADDR_W     (ADDR_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_valid_i  (op_valid),
    .op_i        (op_kind),
    .addr_i      (eff_addr),
    .exc_i       (exc_flush),
    .sc_mem_we_o (sc_mem_we),
    .flag_we_o   (flag_we),
    .flag_val_o  (flag_val)
  );
endmodule

// File: tb/rsv_monitor_bench.sv
`timescale 1ns/1ps
module rsv_monitor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] base_val = '0;
  logic        exc_flush = 1'b0;
  logic [31:0] eff_addr;
  logic        sc_mem_we, flag_we, flag_val;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  bit          m_rsv;
  logic [31:0] m_addr;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  rsv_monitor u_rsv_monitor (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .instr(instr),
    .base_val(base_val), .exc_flush(exc_flush), .eff_addr(eff_addr),
    .sc_mem_we(sc_mem_we), .flag_we(flag_we), .flag_val(flag_val)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ll(logic [15:0] off);
    return {6'h1B, 5'd3, 5'd4, off};
  endfunction
  function automatic logic [31:0] mk_st(logic [5:0] opc, logic [15:0] off);
    return {opc, off[15:11], 5'd4, 5'd5, off[10:0]};
  endfunction

  // One cycle: drive after falling edge, check outputs, then advance the model at the rising edge.
  task automatic step(bit v, logic [31:0] ins, logic [31:0] base, bit exc, string tag);
    logic [5:0]  opc;
    logic [15:0] off;
    logic [31:0] ea;
    bit is_ll, is_sc, is_st, acc, hit, e_we, e_flag;
    @(negedge clk);
    op_valid = v; instr = ins; base_val = base; exc_flush = exc;
    #1;
    opc   = ins[31:26];
    is_ll = (opc == 6'h1B);
    is_sc = (opc == 6'h33);
    is_st = (opc == 6'h35) || (opc == 6'h36) || (opc == 6'h37);
    off   = (is_sc || is_st) ? {ins[25:21], ins[10:0]} : ins[15:0];
    ea    = base + {{16{off[15]}}, off};
    acc   = v && !exc && (is_ll || is_sc || is_st);
    hit   = m_rsv && (ea == m_addr);
    e_we  = acc && is_sc;
    e_flag = e_we && hit;
    chk({tag, " R3 eff_addr"}, eff_addr, ea);
    chk({tag, " R11 flag_we"}, {31'd0, flag_we}, {31'd0, e_we});
    chk({tag, " R5/R6 flag_val"}, {31'd0, flag_val}, {31'd0, e_flag});
    chk({tag, " R5/R6 sc_mem_we"}, {31'd0, sc_mem_we}, {31'd0, e_flag});
    @(posedge clk);
    if (exc) m_rsv = 0;
    else if (acc) begin
      if (is_ll) begin m_rsv = 1; m_addr = ea; end
      else if (is_sc) m_rsv = 0;
      else if ({ea[31:2], 2'b00} == m_addr) m_rsv = 0;
    end
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    m_rsv = 0; m_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1: SC straight after reset fails
    step(1, mk_st(6'h33, 16'h0000), 32'h0, 0, "R1");
    // R4 R5: LL then SC next cycle, same address
    step(1, mk_ll(16'h0010), 32'h100, 0, "R4 ll");
    step(1, mk_st(6'h33, 16'h0010), 32'h100, 0, "R4 sc");
    // R7: second SC fails
    step(1, mk_st(6'h33, 16'h0010), 32'h100, 0, "R7");
    // R6: SC to different address fails
    step(1, mk_ll(16'hFFFC), 32'h200, 0, "R3 neg");
    step(1, mk_st(6'h33, 16'h0000), 32'h1FC, 0, "R6 alias");
    step(1, mk_ll(16'h0008), 32'h200, 0, "R6 ll");
    step(1, mk_st(6'h33, 16'h000C), 32'h200, 0, "R6 miss");
    // R8: byte store inside reserved word clears; other word keeps
    step(1, mk_ll(16'h0040), 32'h300, 0, "R8 ll");
    step(1, mk_st(6'h36, 16'h0043), 32'h300, 0, "R8 sb hit");
    step(1, mk_st(6'h33, 16'h0040), 32'h300, 0, "R8 sc after hit");
    step(1, mk_ll(16'h0040), 32'h300, 0, "R8 ll2");
    step(1, mk_st(6'h35, 16'h0044), 32'h300, 0, "R8 sw other");
    step(1, mk_st(6'h37, 16'h003E), 32'h300, 0, "R8 sh other");
    step(1, mk_st(6'h33, 16'h0040), 32'h300, 0, "R8 sc kept");
    // R9: idle cycles hold
    step(1, mk_ll(16'h0800), 32'h0, 0, "R9 ll");
    for (int i = 0; i < 5; i++) step(0, mk_st(6'h35, 16'h0800), 32'h0, 0, "R9 idle");
    step(1, mk_st(6'h33, 16'h0800), 32'h0, 0, "R9 sc");
    // R2: unknown opcodes with valid have no effect
    step(1, mk_ll(16'h0020), 32'h0, 0, "R2 ll");
    for (int o = 0; o < 64; o++)
      if (o != 'h1B && o != 'h33 && !(o >= 'h35 && o <= 'h37))
        step(1, {o[5:0], 5'd0, 5'd0, 16'h0020}, 32'h0, 0, "R2 other");
    step(1, mk_st(6'h33, 16'h0020), 32'h0, 0, "R2 sc");
    // R10: exception clears; op with exception not accepted
    step(1, mk_ll(16'h0030), 32'h0, 0, "R10 ll");
    step(0, 32'h0, 32'h0, 1, "R10 exc");
    step(1, mk_st(6'h33, 16'h0030), 32'h0, 0, "R10 sc");
    step(1, mk_ll(16'h0030), 32'h0, 1, "R10 ll+exc");
    step(1, mk_st(6'h33, 16'h0030), 32'h0, 0, "R10 sc2");
    step(1, mk_ll(16'h0030), 32'h0, 0, "R10 ll3");
    step(1, mk_st(6'h33, 16'h0030), 32'h0, 1, "R10 sc+exc");
    // Pseudo-random sweep over a small pool of words
    for (int i = 0; i < 6000; i++) begin
      logic [5:0]  opc;
      logic [15:0] off;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      case (lfsr[2:0])
        3'd0, 3'd1: opc = 6'h1B;
        3'd2, 3'd3: opc = 6'h33;
        3'd4: opc = 6'h35;
        3'd5: opc = 6'h36;
        3'd6: opc = 6'h37;
        default: opc = 6'h10;
      endcase
      off = {12'h000, lfsr[6:5], (lfsr[7] ? lfsr[9:8] : 2'b00)};
      if (lfsr[10]) off = -off;
      step(lfsr[14:11] != 0, (opc == 6'h1B || opc == 6'h10) ? {opc, 10'd0, off} : mk_st(opc, off),
           32'h4000, lfsr[20:15] == 0, "SWEEP");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule